// File: doc/BRIEF.md
# Dual-Address I2C Slave Controller

This block is the slave side of an I2C-style two-wire controller, working one byte at a time. It watches the SCL and SDA lines, which arrive already synchronized to `clk`. After every Start condition, including a repeated Start, it takes the first byte as a 7-bit address followed by a direction bit. It compares that address with two own addresses and with the all-zeros general-call address. Each own address has its own enable, and the general-call address has an enable of its own. On a hit it acknowledges the address and raises a new-match flag together with the flag of the address that hit. It also reports the direction of the transfer and, when enabled, raises an interrupt.

Data moves through a single byte buffer that a host accesses with read and write strobes. The controller holds SCL low at each acknowledge phase until the host has serviced the buffer or the new-match flag, so the host can be slow without losing data. Both lines are open drain and are modelled as active-high "pull low" enables. Master operation, 10-bit addressing and the pad circuitry are not part of this block.

The state machine has ten states:
- `ST_IDLE`: unaddressed; waits for a Start.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_HOLD`: acknowledges the address and holds SCL low.
- `ST_ADDR_ACK`: acknowledge clock after the address.
- `ST_RX_DATA`: shifts in a data byte.
- `ST_RX_HOLD`: acknowledges the byte and holds SCL low.
- `ST_RX_ACK`: acknowledge clock after a received byte.
- `ST_TX_HOLD`: holds SCL low until a transmit byte is available.
- `ST_TX_DATA`: shifts out a data byte.
- `ST_TX_ACK`: samples the master's acknowledge.

The transitions are:
- Any state goes to `ST_IDLE` on a Stop and to `ST_ADDR` on a Start.
- `ST_ADDR` goes to `ST_ADDR_HOLD` on a hit, or to `ST_IDLE` on a miss, at the falling SCL edge that ends the eighth bit.
- `ST_ADDR_HOLD` goes to `ST_ADDR_ACK` once new-match is clear.
- `ST_ADDR_ACK` goes to `ST_TX_HOLD` (read) or `ST_RX_DATA` (write) at the falling SCL edge.
- `ST_RX_DATA` goes to `ST_RX_HOLD` after eight bits.
- `ST_RX_HOLD` goes to `ST_RX_ACK` once the buffer has been read.
- `ST_RX_ACK` goes back to `ST_RX_DATA` at the falling SCL edge.
- `ST_TX_HOLD` goes to `ST_TX_DATA` once the buffer is full.
- `ST_TX_DATA` goes to `ST_TX_ACK` after eight falling SCL edges.
- `ST_TX_ACK` goes to `ST_IDLE` on a NACK, or to `ST_TX_HOLD` after an ACK.

Top module: `i2c_dual_slave`

## Requirements
- R1: Own address 1 is compared with bits 7:1 of the first byte after a Start (sent MSB first) only while `own_en1` is 1; a hit sets `match1`.
- R2: Own address 2 is compared only while `own_en2` is 1, independently of address 1; a hit sets `match2`.
- R3: An address of all zeros sets `gmatch`, and not `match1` or `match2`, only while `gc_en` is 1 (own addresses programmed non-zero).
- R4: On any hit the slave pulls SDA low through the acknowledge clock and sets `new_match`. On a miss it does not acknowledge, sets no flag and ignores the bus until the next Start.
- R5: Bit 0 of the address byte is the direction bit, where 1 means the master reads. On such a hit, `xmit` and `buf_empty` are set in the same cycle as `new_match`.
- R6: `irq` is 1 exactly while `new_match`, `irq_en` and `nm_irq_en` are all 1.
- R7: After an address hit, SCL is held low until the host pulses `nm_clear`. The bytes that follow are data: a data byte equal to an own address sets no new-match flag.
- R8: When a write transfer receives eight data bits, the byte appears on `buf_rdata` and `rx_full` is set. SCL is held low and the acknowledge is driven until the host pulses `buf_rd`.
- R9: In transmit mode the buffer byte is sent MSB first and `buf_empty` is set again when the byte is taken. After a master ACK, SCL is held low until `buf_wr` fills the buffer.
- R10: A master NACK after a transmitted byte releases both lines, clears `match1`, `match2`, `gmatch` and `xmit`, and leaves the slave unaddressed until the next Start.
- R11: A repeated Start with no Stop before it re-runs the address comparison and replaces the match and direction flags.
- R12: A Stop returns the slave to idle, releases both lines and clears the match and direction flags.
- R13: After reset, both lines are released and every status output and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| scl_drive_low | output | 1 | 1 pulls SCL low (clock hold) |
| sda_drive_low | output | 1 | 1 pulls SDA low (acknowledge or data 0) |
| own_addr1 | input | 7 | Own address 1 |
| own_en1 | input | 1 | Enables comparison with own address 1 |
| own_addr2 | input | 7 | Own address 2 |
| own_en2 | input | 1 | Enables comparison with own address 2 |
| gc_en | input | 1 | Enables the general-call match |
| irq_en | input | 1 | Global interrupt enable |
| nm_irq_en | input | 1 | New-match interrupt enable |
| buf_wdata | input | 8 | Transmit byte written by the host |
| buf_wr | input | 1 | One-cycle strobe: write `buf_wdata` into the buffer |
| buf_rd | input | 1 | One-cycle strobe: host has read the buffer |
| nm_clear | input | 1 | One-cycle strobe: clear `new_match` |
| buf_rdata | output | 8 | Buffer contents |
| match1 | output | 1 | Own address 1 hit |
| match2 | output | 1 | Own address 2 hit |
| gmatch | output | 1 | General-call hit |
| new_match | output | 1 | Address byte acknowledged and not yet serviced |
| xmit | output | 1 | Slave transmit (master read) mode |
| buf_empty | output | 1 | Transmit buffer needs a byte |
| rx_full | output | 1 | Received byte waiting in the buffer |
| irq | output | 1 | Interrupt request |

## Verification
Every result is registered once.

- **Line events.** A new state and its flags follow one clock after the edge of `scl_in` or `sda_in` that caused them, and the line drives follow from the state in that same cycle. The bench moves SCL and SDA several clocks apart and samples on the falling clock edge, at least three clocks after the bus change it is checking.
- **Host strobes.** A strobe takes effect on the next clock, and a held SCL is released one clock later. The bench therefore checks a hold eight clocks after it releases its own SCL. It waits for the bus SCL to rise before it samples an acknowledge or a data bit.
- **Address sweep.** All 128 addresses are swept under four enable configurations. The expected hit flags and interrupt are computed in the bench by comparing each address with the programmed values.

// File: rtl/i2c_dslv_pkg.sv
package i2c_dslv_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_HOLD,
        ST_ADDR_ACK,
        ST_RX_DATA,
        ST_RX_HOLD,
        ST_RX_ACK,
        ST_TX_HOLD,
        ST_TX_DATA,
        ST_TX_ACK
    } slv_state_e;

endpackage

// File: rtl/i2c_dslv_linemon.sv
// Bus condition detector: compares current line levels with the previous sample.
module i2c_dslv_linemon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic ev_start,
    output logic ev_stop,
    output logic ev_rise,
    output logic ev_fall
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_in;
            sda_q <= sda_in;
        end
    end

    // SDA edges while SCL stays high mark Start and Stop conditions
    assign ev_start = scl_in & scl_q & sda_q & ~sda_in;
    assign ev_stop  = scl_in & scl_q & ~sda_q & sda_in;
    assign ev_rise  = scl_in & ~scl_q;
    assign ev_fall  = ~scl_in & scl_q;

endmodule

// File: rtl/i2c_dslv_addr_match.sv
// Address comparator: a set of enabled own addresses plus the general call.
module i2c_dslv_addr_match #(
    parameter int ADDR_W  = 7,
    parameter int NUM_OWN = 2
) (
    input  logic [ADDR_W-1:0]              rx_addr,
    input  logic [NUM_OWN-1:0][ADDR_W-1:0] own_addr,
    input  logic [NUM_OWN-1:0]             own_en,
    input  logic                           gc_en,
    output logic [NUM_OWN-1:0]             own_hit,
    output logic                           gc_hit,
    output logic                           any_hit
);

    for (genvar g = 0; g < NUM_OWN; g++) begin : g_own
        assign own_hit[g] = own_en[g] && (rx_addr == own_addr[g]);
    end

    assign gc_hit  = gc_en && (rx_addr == '0);
    assign any_hit = (|own_hit) | gc_hit;

endmodule

// File: rtl/i2c_dslv_shift.sv
// Byte shifter with bit counter, used for both receive and transmit.
module i2c_dslv_shift #(
    parameter int DATA_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             clr,
    input  logic                             load,
    input  logic                             shift_in,
    input  logic                             shift_out,
    input  logic                             sda_bit,
    input  logic [DATA_W-1:0]                load_data,
    output logic [DATA_W-1:0]                sh_q,
    output logic [$clog2(DATA_W+1)-1:0]      cnt_q
);

    localparam int CNT_W = $clog2(DATA_W+1);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (load) begin
            sh_q  <= load_data;
            cnt_q <= '0;
        end else if (shift_in) begin
            sh_q  <= {sh_q[DATA_W-2:0], sda_bit};
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (shift_out) begin
            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/i2c_dual_slave.sv
module i2c_dual_slave #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic [ADDR_W-1:0] own_addr1,
    input  logic              own_en1,
    input  logic [ADDR_W-1:0] own_addr2,
    input  logic              own_en2,
    input  logic              gc_en,
    input  logic              irq_en,
    input  logic              nm_irq_en,
    input  logic [DATA_W-1:0] buf_wdata,
    input  logic              buf_wr,
    input  logic              buf_rd,
    input  logic              nm_clear,
    output logic [DATA_W-1:0] buf_rdata,
    output logic              match1,
    output logic              match2,
    output logic              gmatch,
    output logic              new_match,
    output logic              xmit,
    output logic              buf_empty,
    output logic              rx_full,
    output logic              irq
);

    import i2c_dslv_pkg::*;

    localparam int NUM_OWN = 2;
    localparam int CNT_W   = $clog2(DATA_W+1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W-1);

    slv_state_e st_q, st_d;

    logic ev_start, ev_stop, ev_rise, ev_fall;
    logic [DATA_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [NUM_OWN-1:0] own_hit;
    logic gc_hit, any_hit;

    logic match1_q, match2_q, gmatch_q, nm_q, xmit_q, buf_empty_q, rx_full_q;
    logic [DATA_W-1:0] buf_q;

    logic sh_clr, sh_load, sh_in, sh_out;
    logic byte_end, addr_take, rx_take, tx_nack;

    // ---------------- line events ----------------
    i2c_dslv_linemon u_linemon (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .ev_start (ev_start),
        .ev_stop  (ev_stop),
        .ev_rise  (ev_rise),
        .ev_fall  (ev_fall)
    );

    // ---------------- shifter ----------------
    i2c_dslv_shift #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (sh_clr),
        .load      (sh_load),
        .shift_in  (sh_in),
        .shift_out (sh_out),
        .sda_bit   (sda_in),
        .load_data (buf_q),
        .sh_q      (sh_q),
        .cnt_q     (cnt_q)
    );

    // ---------------- address compare ----------------
    i2c_dslv_addr_match #(.ADDR_W(ADDR_W), .NUM_OWN(NUM_OWN)) u_match (
        .rx_addr  (sh_q[DATA_W-1:1]),
        .own_addr ({own_addr2, own_addr1}),
        .own_en   ({own_en2, own_en1}),
        .gc_en    (gc_en),
        .own_hit  (own_hit),
        .gc_hit   (gc_hit),
        .any_hit  (any_hit)
    );

    // ---------------- control strobes ----------------
    assign byte_end  = ev_fall && (cnt_q == CNT_FULL);
    assign addr_take = (st_q == ST_ADDR) && byte_end && any_hit;
    assign rx_take   = (st_q == ST_RX_DATA) && byte_end;
    assign tx_nack   = (st_q == ST_TX_ACK) && ev_rise && sda_in;

    always_comb begin
        sh_clr  = ev_start
                | ((st_q == ST_ADDR_ACK) && ev_fall)
                | ((st_q == ST_RX_ACK) && ev_fall);
        sh_load = (st_q == ST_TX_HOLD) && !buf_empty_q && !ev_start && !ev_stop;
        sh_in   = ev_rise && ((st_q == ST_ADDR) || (st_q == ST_RX_DATA));
        sh_out  = ev_fall && (st_q == ST_TX_DATA);
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ---------------- next state ----------------
    always_comb begin
        st_d = st_q;
        if (ev_stop) begin
            st_d = ST_IDLE;
        end else if (ev_start) begin
            st_d = ST_ADDR;
        end else begin
            unique case (st_q)
                ST_IDLE:      st_d = ST_IDLE;
                ST_ADDR:      if (byte_end) st_d = any_hit ? ST_ADDR_HOLD : ST_IDLE;
                ST_ADDR_HOLD: if (!nm_q) st_d = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (ev_fall) st_d = xmit_q ? ST_TX_HOLD : ST_RX_DATA;
                ST_RX_DATA:   if (byte_end) st_d = ST_RX_HOLD;
                ST_RX_HOLD:   if (!rx_full_q) st_d = ST_RX_ACK;
                ST_RX_ACK:    if (ev_fall) st_d = ST_RX_DATA;
                ST_TX_HOLD:   if (!buf_empty_q) st_d = ST_TX_DATA;
                ST_TX_DATA:   if (ev_fall && (cnt_q == CNT_LAST)) st_d = ST_TX_ACK;
                ST_TX_ACK: begin
                    if (ev_rise && sda_in) st_d = ST_IDLE;
                    else if (ev_fall)      st_d = ST_TX_HOLD;
                end
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    // ---------------- line drive outputs ----------------
    always_comb begin
        scl_drive_low = 1'b0;
        sda_drive_low = 1'b0;
        unique case (st_q)
            ST_ADDR_HOLD: begin scl_drive_low = 1'b1; sda_drive_low = 1'b1; end
            ST_ADDR_ACK:  sda_drive_low = 1'b1;
            ST_RX_HOLD:   begin scl_drive_low = 1'b1; sda_drive_low = 1'b1; end
            ST_RX_ACK:    sda_drive_low = 1'b1;
            ST_TX_HOLD:   scl_drive_low = 1'b1;
            ST_TX_DATA:   sda_drive_low = ~sh_q[DATA_W-1];
            default: begin
                scl_drive_low = 1'b0;
                sda_drive_low = 1'b0;
            end
        endcase
    end

    // ---------------- flags and buffer ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match1_q    <= 1'b0;
            match2_q    <= 1'b0;
            gmatch_q    <= 1'b0;
            nm_q        <= 1'b0;
            xmit_q      <= 1'b0;
            buf_empty_q <= 1'b0;
            rx_full_q   <= 1'b0;
            buf_q       <= '0;
        end else begin
            if (ev_stop) begin
                match1_q    <= 1'b0;
                match2_q    <= 1'b0;
                gmatch_q    <= 1'b0;
                xmit_q      <= 1'b0;
                buf_empty_q <= 1'b0;
            end else if (ev_start) begin
                match1_q <= 1'b0;
                match2_q <= 1'b0;
                gmatch_q <= 1'b0;
                xmit_q   <= 1'b0;
            end
            if (tx_nack) begin
                match1_q <= 1'b0;
                match2_q <= 1'b0;
                gmatch_q <= 1'b0;
                xmit_q   <= 1'b0;
            end
            if (nm_clear) nm_q <= 1'b0;
            if (addr_take) begin
                match1_q <= own_hit[0];
                match2_q <= own_hit[1];
                gmatch_q <= gc_hit;
                nm_q     <= 1'b1;
                xmit_q   <= sh_q[0];
                if (sh_q[0]) buf_empty_q <= 1'b1;
            end
            if (sh_load) buf_empty_q <= 1'b1;
            if (buf_wr) begin
                buf_q       <= buf_wdata;
                buf_empty_q <= 1'b0;
            end
            if (buf_rd) rx_full_q <= 1'b0;
            if (rx_take) begin
                buf_q     <= sh_q;
                rx_full_q <= 1'b1;
            end
        end
    end

    assign match1    = match1_q;
    assign match2    = match2_q;
    assign gmatch    = gmatch_q;
    assign new_match = nm_q;
    assign xmit      = xmit_q;
    assign buf_empty = buf_empty_q;
    assign rx_full   = rx_full_q;
    assign buf_rdata = buf_q;
    assign irq       = nm_q & irq_en & nm_irq_en;

    // ---------------- assertions ----------------
    a_r1_match1_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match1_q) |-> own_en1);

    a_r2_match2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match2_q) |-> own_en2);

    a_r3_gcall_zero_address: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gmatch_q) |-> gc_en && (sh_q[DATA_W-1:1] == '0));

    a_r4_ack_with_new_match: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nm_q) |-> sda_drive_low && scl_drive_low);

    a_r5_read_requests_byte: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(nm_q) && xmit_q) |-> buf_empty_q);

    a_r8_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_RX_HOLD) && rx_full_q && !buf_rd && !ev_start && !ev_stop)
        |=> scl_drive_low && sda_drive_low);

    a_r10_nack_releases: assert property (@(posedge clk) disable iff (!rst_n)
        tx_nack |=> !sda_drive_low && !scl_drive_low && !xmit_q);

    a_r12_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> !scl_drive_low && !sda_drive_low && !match1_q && !match2_q && !gmatch_q);

endmodule

// File: tb/i2c_dual_slave_test.sv
`timescale 1ns/1ps
module i2c_dual_slave_test;

    localparam logic [6:0] A1 = 7'h2A;
    localparam logic [6:0] A2 = 7'h55;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1;
    logic scl_bus, sda_bus;
    logic scl_drive_low, sda_drive_low;
    logic [6:0] own_addr1 = A1, own_addr2 = A2;
    logic own_en1 = 1'b0, own_en2 = 1'b0, gc_en = 1'b0, irq_en = 1'b1, nm_irq_en = 1'b0;
    logic [7:0] buf_wdata = 8'h00;
    logic buf_wr = 1'b0, buf_rd = 1'b0, nm_clear = 1'b0;
    logic [7:0] buf_rdata;
    logic match1, match2, gmatch, new_match, xmit, buf_empty, rx_full, irq;

    assign scl_bus = scl_m & ~scl_drive_low;
    assign sda_bus = sda_m & ~sda_drive_low;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    i2c_dual_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .own_addr1(own_addr1), .own_en1(own_en1), .own_addr2(own_addr2), .own_en2(own_en2),
        .gc_en(gc_en), .irq_en(irq_en), .nm_irq_en(nm_irq_en),
        .buf_wdata(buf_wdata), .buf_wr(buf_wr), .buf_rd(buf_rd), .nm_clear(nm_clear),
        .buf_rdata(buf_rdata), .match1(match1), .match2(match2), .gmatch(gmatch),
        .new_match(new_match), .xmit(xmit), .buf_empty(buf_empty), .rx_full(rx_full), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wcy(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_high();
        while (!scl_bus) wcy(1);
    endtask

    task automatic m_start();
        sda_m = 1'b1; wcy(3);
        scl_m = 1'b1; wait_high(); wcy(4);
        sda_m = 1'b0; wcy(4);
        scl_m = 1'b0; wcy(3);
    endtask

    task automatic m_stop();
        sda_m = 1'b0; wcy(3);
        scl_m = 1'b1; wait_high(); wcy(4);
        sda_m = 1'b1; wcy(4);
    endtask

    task automatic m_bit(input logic b);
        sda_m = b; wcy(3);
        scl_m = 1'b1; wait_high(); wcy(6);
        scl_m = 1'b0; wcy(3);
    endtask

    task automatic m_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) m_bit(v[i]);
    endtask

    task automatic m_rbit_tail(output logic b);
        wait_high(); wcy(3);
        b = sda_bus; wcy(3);
        scl_m = 1'b0; wcy(3);
    endtask

    task automatic m_rbyte(input bit started, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            if (!(i == 7 && started)) begin
                sda_m = 1'b1; wcy(3); scl_m = 1'b1;
            end
            m_rbit_tail(b);
            v[i] = b;
        end
    endtask

    // release SDA, raise own SCL and give the slave time to hold it
    task automatic ack_begin();
        sda_m = 1'b1; wcy(3);
        scl_m = 1'b1; wcy(8);
    endtask

    task automatic ack_end(output logic acked);
        logic b;
        m_rbit_tail(b);
        acked = ~b;
    endtask

    task automatic h_nm_clear();
        nm_clear = 1'b1; wcy(1); nm_clear = 1'b0; wcy(1);
    endtask

    task automatic h_read();
        buf_rd = 1'b1; wcy(1); buf_rd = 1'b0; wcy(1);
    endtask

    task automatic h_write(input logic [7:0] v);
        buf_wdata = v; buf_wr = 1'b1; wcy(1); buf_wr = 1'b0; wcy(1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] rv;
        wcy(5);
        // R13: reset state
        chk("R13 reset outputs",
            {22'd0, scl_drive_low, sda_drive_low, match1, match2, gmatch, new_match, xmit, buf_empty, rx_full, irq},
            32'd0);
        rst_n = 1'b1;
        wcy(4);

        // Sweep of all addresses under four enable configurations (R1 R2 R3 R4 R6 R7)
        for (int c = 0; c < 4; c++) begin
            own_en1   = (c == 0) || (c == 1);
            own_en2   = (c == 0) || (c == 2);
            gc_en     = (c == 0) || (c == 2);
            nm_irq_en = (c % 2) == 0;
            for (int a = 0; a < 128; a++) begin
                logic h1, h2, hg, hit;
                h1  = own_en1 && (7'(a) == A1);
                h2  = own_en2 && (7'(a) == A2);
                hg  = gc_en && (a == 0);
                hit = h1 | h2 | hg;
                m_start();
                m_byte({7'(a), 1'b0});
                ack_begin();
                chk("R1/R2/R3/R4/R6/R7 address sweep flags",
                    {26'd0, scl_bus, match1, match2, gmatch, new_match, irq},
                    {26'd0, ~hit, h1, h2, hg, hit, hit & nm_irq_en});
                if (hit) h_nm_clear();
                ack_end(ack);
                chk("R4 acknowledge on hit only", {31'd0, ack}, {31'd0, hit});
                m_stop();
            end
        end

        // Receive path (R8, R7)
        own_en1 = 1'b1; own_en2 = 1'b1; gc_en = 1'b0; nm_irq_en = 1'b1;
        m_start();
        m_byte({A1, 1'b0});
        ack_begin();
        chk("R5 write direction", {31'd0, xmit}, 32'd0);
        h_nm_clear();
        ack_end(ack);
        m_byte(8'h54);
        ack_begin();
        chk("R8 hold and byte after receive",
            {21'd0, scl_bus, sda_bus, rx_full, buf_rdata},
            {21'd0, 1'b0, 1'b0, 1'b1, 8'h54});
        chk("R7 data byte does not set new match", {31'd0, new_match}, 32'd0);
        wcy(20);
        chk("R8 hold persists until read", {31'd0, scl_bus}, 32'd0);
        h_read();
        ack_end(ack);
        chk("R8 receive ack after read", {30'd0, ack, rx_full}, {30'd0, 1'b1, 1'b0});
        m_byte(8'hC7);
        ack_begin();
        chk("R8 second byte", {23'd0, rx_full, buf_rdata}, {23'd0, 1'b1, 8'hC7});
        h_read();
        ack_end(ack);
        m_stop();
        chk("R12 stop clears flags",
            {27'd0, scl_drive_low, sda_drive_low, match1, match2, gmatch}, 32'd0);

        // Transmit path (R5, R9, R10)
        m_start();
        m_byte({A1, 1'b1});
        ack_begin();
        chk("R5 read sets xmit and buf_empty",
            {28'd0, match1, new_match, xmit, buf_empty}, {28'd0, 4'b1111});
        h_write(8'h96);
        h_nm_clear();
        ack_end(ack);
        chk("R4 read address acked", {31'd0, ack}, 32'd1);
        m_rbyte(1'b0, rv);
        chk("R9 first byte MSB first", {24'd0, rv}, {24'd0, 8'h96});
        chk("R9 buffer empty after take", {31'd0, buf_empty}, 32'd1);
        m_bit(1'b0);
        ack_begin();
        chk("R9 hold after ack while empty", {31'd0, scl_bus}, 32'd0);
        h_write(8'h5A);
        m_rbyte(1'b1, rv);
        chk("R9 second byte", {24'd0, rv}, {24'd0, 8'h5A});
        m_bit(1'b1);
        wcy(2);
        chk("R10 nack clears state",
            {28'd0, match1, xmit, sda_drive_low, scl_drive_low}, 32'd0);
        m_byte(8'h54);
        ack_begin();
        chk("R10 unaddressed after nack",
            {29'd0, scl_bus, sda_bus, new_match}, {29'd0, 1'b1, 1'b1, 1'b0});
        ack_end(ack);
        m_stop();

        // Repeated start (R11)
        m_start();
        m_byte({A1, 1'b0});
        ack_begin();
        chk("R11 first address", {29'd0, match1, match2, xmit}, {29'd0, 3'b100});
        h_nm_clear();
        ack_end(ack);
        m_start();
        m_byte({A2, 1'b1});
        ack_begin();
        chk("R11 repeated start readdresses",
            {28'd0, match1, match2, xmit, buf_empty}, {28'd0, 4'b0111});
        h_write(8'hC3);
        h_nm_clear();
        ack_end(ack);
        m_rbyte(1'b0, rv);
        chk("R11 byte after repeated start", {24'd0, rv}, {24'd0, 8'hC3});
        m_bit(1'b1);
        m_stop();
        wcy(2);
        chk("R12 stop releases lines",
            {26'd0, scl_drive_low, sda_drive_low, match1, match2, gmatch, xmit}, 32'd0);

        // R6: interrupt gated by global enable
        irq_en = 1'b0;
        m_start();
        m_byte({A2, 1'b0});
        ack_begin();
        chk("R6 irq needs global enable", {30'd0, new_match, irq}, {30'd0, 2'b10});
        irq_en = 1'b1; wcy(1);
        chk("R6 irq with both enables", {31'd0, irq}, 32'd1);
        h_nm_clear();
        ack_end(ack);
        m_stop();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule